// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a bus-mapped watchdog. A down-counter is loaded from a programmable preset. While counting is enabled it decrements once per tick. The tick is either every bus clock cycle or a slow external tick-enable strobe, chosen by a control bit. Software keeps the watchdog from firing by writing a 16-bit key to a write-only restart location, which reloads the counter from the preset.

When a tick would take the counter to zero, the block registers an expiry. On expiry the counter reloads from the preset, so expiry repeats periodically while counting stays enabled. A sticky status flag is also set, and it is cleared only by a write to a separate clear location. Up to three outputs (system reset request, system interrupt, external signal) can each be enabled. Every enabled output is held high for a programmable number of cycles after each expiry.

The register port is a plain 32-bit word interface with a byte address. A write completes in the cycle it is presented. Read data appears on the cycle after a read strobe.

Top module: `wdg_timer`

## Requirements
- R1: After reset the preset register reads 0x03EF1480, the counter reads the same value, the hold-length register reads 0xFF, and control and status read 0. All three outputs are low.
- R2: Word offsets are counter 0x00 (read only), preset 0x04, restart 0x08 (write only), control 0x0C, status 0x10 (read only), clear 0x14 (write only) and hold length 0x18. Read data is valid one cycle after the read strobe. Control reads only bits [4:0], the hold length reads only its low 8 bits, and every other bit reads 0. Write-only and unmapped offsets read 0.
- R3: With control bit 0 set, the counter decreases by one every clock cycle when control bit 4 is 0. When control bit 4 is 1 it decreases only in cycles where slow_tick is high.
- R4: With control bit 0 clear, the counter holds its value.
- R5: A write to the restart offset whose bits [15:0] equal 0x5AB9 loads the counter from the preset on that edge, whatever bits [31:16] hold. A write with any other low half leaves the counter unchanged.
- R6: A counting tick that finds the counter at 1 (or 0) is an expiry. The counter reloads from the preset on that edge, so expiries recur every preset-value ticks while counting stays enabled.
- R7: An expiry sets status bit 0. The bit stays set until a write to the clear offset with bit 0 equal to 1. A clear write with bit 0 equal to 0 has no effect, and an expiry in the same cycle as a clear wins.
- R8: Control bit 1 enables the reset output, bit 2 the interrupt output and bit 3 the external output. An enabled output rises on the edge of an expiry and stays high for hold length + 1 cycles. A disabled output stays low.
- R9: A restart write with the correct key reloads the counter even while counting is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | Slow tick enable, used when control bit 4 is 1 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address, bits [4:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| sys_rst_o | output | 1 | Held reset request on expiry |
| sys_irq_o | output | 1 | Held interrupt on expiry |
| ext_sig_o | output | 1 | Held external signal on expiry |

## Verification
The assertions assume that a read and a write never share a cycle. They also assume that the restart key and a preset write never arrive together, because the reload property compares against the preset of the previous cycle. The stimulus drives one bus operation per task call, changes inputs only on falling edges, and always writes the preset before the restart key. The slow tick is pulsed one cycle at a time, so its effect on the counter can be counted exactly.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int OFS_COUNT   = 0;
  localparam int OFS_LOAD    = 1;
  localparam int OFS_RESTART = 2;
  localparam int OFS_CTRL    = 3;
  localparam int OFS_STAT    = 4;
  localparam int OFS_CLEAR   = 5;
  localparam int OFS_LEN     = 6;

  localparam logic [15:0] RESTART_KEY = 16'h5AB9;
  localparam int NUM_OUT = 3;

  typedef struct packed {
    logic clk_sel;
    logic ext_en;
    logic irq_en;
    logic rst_en;
    logic run;
  } wdg_ctrl_t;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int LEN_W  = 8,
  parameter logic [DATA_W-1:0] LOAD_RST = 32'h03EF1480,
  parameter logic [LEN_W-1:0]  LEN_RST  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              status_i,
  output logic [DATA_W-1:0] load_o,
  output wdg_ctrl_t         ctrl_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              restart_o,
  output logic              clear_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int CTRL_W = $bits(wdg_ctrl_t);

  logic [IDX_W-1:0] idx;
  logic unused_lsb;

  assign idx        = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];

  assign restart_o = bus_wr && (idx == IDX_W'(OFS_RESTART)) &&
                     (bus_wdata[15:0] == RESTART_KEY);
  assign clear_o   = bus_wr && (idx == IDX_W'(OFS_CLEAR)) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      load_o <= LOAD_RST;
      ctrl_o <= '0;
      len_o  <= LEN_RST;
    end else if (bus_wr) begin
      if (idx == IDX_W'(OFS_LOAD)) load_o <= bus_wdata;
      if (idx == IDX_W'(OFS_CTRL)) ctrl_o <= wdg_ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (idx == IDX_W'(OFS_LEN))  len_o  <= bus_wdata[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (idx)
        IDX_W'(OFS_COUNT): bus_rdata <= cnt_i;
        IDX_W'(OFS_LOAD):  bus_rdata <= load_o;
        IDX_W'(OFS_CTRL):  bus_rdata <= DATA_W'(ctrl_o);
        IDX_W'(OFS_STAT):  bus_rdata <= DATA_W'(status_i);
        IDX_W'(OFS_LEN):   bus_rdata <= DATA_W'(len_o);
        default:           bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = 32'h03EF1480
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clk_sel,
  input  logic             slow_tick,
  input  logic             restart,
  input  logic             clear,
  input  logic [CNT_W-1:0] load,
  output logic [CNT_W-1:0] cnt_o,
  output logic             status_o,
  output logic             expire_o
);
  logic tick;

  assign tick     = run && (clk_sel ? slow_tick : 1'b1);
  assign expire_o = tick && !restart && (cnt_o <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)           cnt_o <= LOAD_RST;
    else if (restart)  cnt_o <= load;
    else if (expire_o) cnt_o <= load;
    else if (tick)     cnt_o <= cnt_o - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)           status_o <= 1'b0;
    else if (expire_o) status_o <= 1'b1;
    else if (clear)    status_o <= 1'b0;
  end
endmodule

// File: rtl/wdg_hold.sv
module wdg_hold #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [LEN_W-1:0] len,
  output logic             out_o
);
  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_o  <= 1'b0;
      remain <= '0;
    end else if (fire) begin
      out_o  <= 1'b1;
      remain <= len;
    end else if (out_o) begin
      if (remain == '0) out_o <= 1'b0;
      else              remain <= remain - LEN_W'(1);
    end
  end
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int LEN_W  = 8,
  parameter logic [DATA_W-1:0] LOAD_RST = 32'h03EF1480,
  parameter logic [LEN_W-1:0]  LEN_RST  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst_o,
  output logic              sys_irq_o,
  output logic              ext_sig_o
);
  logic [DATA_W-1:0]  cnt;
  logic [DATA_W-1:0]  load;
  logic [LEN_W-1:0]   len;
  wdg_ctrl_t          ctrl;
  logic [4:0]         ctrl_raw;
  logic               status;
  logic               expire;
  logic               restart;
  logic               clear;
  logic [NUM_OUT-1:0] en_vec;
  logic [NUM_OUT-1:0] out_vec;

  assign ctrl_raw = ctrl;
  assign en_vec   = {ctrl.ext_en, ctrl.irq_en, ctrl.rst_en};

  wdg_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .LOAD_RST(LOAD_RST), .LEN_RST(LEN_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_i(cnt), .status_i(status), .load_o(load), .ctrl_o(ctrl),
    .len_o(len), .restart_o(restart), .clear_o(clear)
  );

  wdg_count #(.CNT_W(DATA_W), .LOAD_RST(LOAD_RST)) u_count (
    .clk(clk), .rst(rst), .run(ctrl.run), .clk_sel(ctrl.clk_sel),
    .slow_tick(slow_tick), .restart(restart), .clear(clear),
    .load(load), .cnt_o(cnt), .status_o(status), .expire_o(expire)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_hold
    wdg_hold #(.LEN_W(LEN_W)) u_hold (
      .clk(clk), .rst(rst), .fire(expire && en_vec[g]),
      .len(len), .out_o(out_vec[g])
    );
  end

  assign sys_rst_o = out_vec[0];
  assign sys_irq_o = out_vec[1];
  assign ext_sig_o = out_vec[2];
endmodule

// File: rtl/wdg_timer_chk.sv
module wdg_timer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       key_bits,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] load,
  input logic [4:0]        ctrl,
  input logic              status,
  input logic              expire,
  input logic              sys_rst_o
);
  logic key_wr;
  logic ctrl_rd;

  assign key_wr  = bus_wr && (bus_addr[ADDR_W-1:2] == 3'd2) && (key_bits == 16'h5AB9);
  assign ctrl_rd = bus_rd && (bus_addr[ADDR_W-1:2] == 3'd3);

  // R2
  ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(ctrl_rd) |-> bus_rdata[DATA_W-1:5] == '0);

  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl[0] && !ctrl[4] && !key_wr && (cnt > 1) |=> cnt == $past(cnt) - 1);

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl[0] && !key_wr |=> $stable(cnt));

  // R5
  key_reload_chk: assert property (@(posedge clk) disable iff (rst)
    key_wr |=> cnt == $past(load));

  // R7
  status_set_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> status);

  // R8
  rst_out_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> $past(ctrl[1]) && $past(expire));
endmodule

bind wdg_timer wdg_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .key_bits(bus_wdata[15:0]), .bus_rdata(bus_rdata),
  .cnt(cnt), .load(load), .ctrl(ctrl_raw), .status(status),
  .expire(expire), .sys_rst_o(sys_rst_o)
);

// File: tb/wdg_timer_bench.sv
module wdg_timer_bench;
  localparam logic [4:0] A_COUNT = 5'h00, A_LOAD = 5'h04, A_RESTART = 5'h08,
                         A_CTRL = 5'h0C, A_STAT = 5'h10, A_CLEAR = 5'h14,
                         A_LEN = 5'h18, A_NONE = 5'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst_o, sys_irq_o, ext_sig_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  always #4 clk = ~clk;

  wdg_timer u_wdg_timer (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sys_rst_o(sys_rst_o), .sys_irq_o(sys_irq_o),
    .ext_sig_o(ext_sig_o)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) rd_d <= bus_rd;

  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(bus_rdata == e, t, bus_rdata, e);
    end
  end

  task automatic outs(input logic r, input logic i, input logic x, input string tag);
    check({sys_rst_o, sys_irq_o, ext_sig_o} == {r, i, x}, tag,
          {29'd0, sys_rst_o, sys_irq_o, ext_sig_o}, {29'd0, r, i, x});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    rd(A_COUNT, 32'h03EF1480, "R1 counter");
    rd(A_LOAD,  32'h03EF1480, "R1 preset");
    rd(A_LEN,   32'h000000FF, "R1 length");
    rd(A_CTRL,  32'h0, "R1 control");
    rd(A_STAT,  32'h0, "R1 status");
    outs(1'b0, 1'b0, 1'b0, "R1 outputs");
    // R5 key reload, R2 write-only reads
    wr(A_LOAD, 32'd100);
    wr(A_RESTART, 32'h00005AB9);
    rd(A_COUNT, 32'd100, "R5 key reload");
    rd(A_RESTART, 32'h0, "R2 restart reads 0");
    rd(A_CLEAR, 32'h0, "R2 clear reads 0");
    rd(A_NONE, 32'h0, "R2 unmapped reads 0");
    // R3 count on bus clock: 10 decrements
    wr(A_CTRL, 32'h1);
    idle(9);
    wr(A_CTRL, 32'h0);
    rd(A_COUNT, 32'd90, "R3 bus clock count");
    // R4 hold while disabled
    idle(5);
    rd(A_COUNT, 32'd90, "R4 hold");
    // R5 wrong key, key with upper bits set; R9 restart while disabled
    wr(A_RESTART, 32'h00001234);
    rd(A_COUNT, 32'd90, "R5 wrong key ignored");
    wr(A_RESTART, 32'hFFFF5AB9);
    rd(A_COUNT, 32'd100, "R9 restart while disabled");
    // R3 slow tick selection
    wr(A_CTRL, 32'h11);
    idle(6);
    rd(A_COUNT, 32'd100, "R3 no slow tick");
    for (int p = 0; p < 3; p++) begin
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
      idle(1);
    end
    wr(A_CTRL, 32'h0);
    rd(A_COUNT, 32'd97, "R3 three slow ticks");
    // R2 reserved control bits
    wr(A_CTRL, 32'hFFFFFFE0);
    rd(A_CTRL, 32'h0, "R2 control reserved");
    wr(A_CTRL, 32'hFFFFFFEE);
    rd(A_CTRL, 32'h0000000E, "R2 control bits");
    wr(A_LEN, 32'h00000103);
    rd(A_LEN, 32'h3, "R2 length width");
    // R6 R8 expiry with reset and interrupt enabled
    wr(A_LOAD, 32'd5);
    wr(A_RESTART, 32'h5AB9);
    wr(A_CTRL, 32'h7);
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      outs((k >= 5 && k <= 8), (k >= 5 && k <= 8), 1'b0, "R8 output hold");
    end
    wr(A_CTRL, 32'h0);
    outs(1'b1, 1'b1, 1'b0, "R6 periodic expiry");
    idle(6);
    outs(1'b0, 1'b0, 1'b0, "R8 outputs released");
    rd(A_COUNT, 32'd5, "R6 reload on expiry");
    // R7 sticky status and clear
    rd(A_STAT, 32'h1, "R7 status set");
    wr(A_CLEAR, 32'h0);
    rd(A_STAT, 32'h1, "R7 clear with 0 ignored");
    wr(A_CLEAR, 32'h1);
    rd(A_STAT, 32'h0, "R7 cleared");
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule